// File: doc/BRIEF.md
# Dual-Band Zero-Crossing Tone-Pair Detector

This block recognises a DTMF tone pair from two one-bit sign streams. An earlier stage has already split the signal into its low-frequency and high-frequency bands and sliced each band to a sign. For each band the block counts master-clock cycles between successive rising zero crossings. It matches every measured period against acceptance windows for the four tones of that band. A band is locked once the same tone has repeated for a run of periods.

When both bands are locked at the same time, the block raises a registered early-valid flag and reports a 2-bit row index for the low band and a 2-bit column index for the high band. If either band loses lock, the flag falls on the next clock. An inhibit input rejects every pair whose high tone is the highest column. A power-down input holds all band state and all outputs cleared. The period windows are computed at elaboration from the clock frequency parameter, so the block can run from any master clock that is fast enough to keep the windows of neighbouring tones apart.

Top module: `dtmf_zc_pair_detect`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `early_valid_o`, `row_o` and `col_o` are all 0.
- R2: The low-band tones 697, 770, 852 and 941 Hz are reported on `row_o` as 0, 1, 2 and 3.
- R3: The high-band tones 1209, 1336, 1477 and 1633 Hz are reported on `col_o` as 0, 1, 2 and 3.
- R4: `early_valid_o` is 1 only in the cycle after both bands were locked. The row and column are loaded in the same clock edge.
- R5: A rising crossing is a cycle with the sign at 1 after a cycle with the sign at 0. The period is the number of clocks between two rising crossings. A period P matches tone f when ceil(CLK_HZ·40/(f·41)) ≤ P ≤ floor(CLK_HZ·40/(f·39)), which is a ±2.5 % frequency window.
- R6: A band locks only after LOCK_N (default 4) consecutive periods that match the same tone. The first rising crossing after silence only opens a measurement, so lock needs LOCK_N+1 crossings.
- R7: A single period that matches no tone clears the lock of its band, and `early_valid_o` falls on the following clock.
- R8: When a band's count reaches one more than the upper bound of its lowest tone with no crossing, that band counts as silent. Its lock clears without waiting for another crossing.
- R9: While `inhibit_i` is 1, a pair whose high tone is column 3 (1633 Hz) does not raise `early_valid_o`. Pairs in other columns are unaffected.
- R10: While `pwr_down_i` is 1, the band state is cleared and all three outputs read 0 from the next clock on.
- R11: After `early_valid_o` falls, `row_o` and `col_o` keep the last valid pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; the time base for period counts |
| rst_n | input | 1 | Active-low synchronous reset |
| low_sign_i | input | 1 | Sliced sign of the low-frequency band |
| high_sign_i | input | 1 | Sliced sign of the high-frequency band |
| inhibit_i | input | 1 | Rejects pairs in column 3 |
| pwr_down_i | input | 1 | Holds the block idle with outputs cleared |
| early_valid_o | output | 1 | Both bands locked on a valid pair |
| row_o | output | 2 | Low-band tone index of the last valid pair |
| col_o | output | 2 | High-band tone index of the last valid pair |

## Verification
The in-RTL properties check the following on every cycle:
- the flag never stands without both locks one cycle earlier;
- it falls the cycle after a lock is lost;
- an inhibited column-3 pair never shows as valid;
- silence clears a band's run;
- a lock only appears right after a crossing;
- power-down clears the outputs.

The run length of exactly LOCK_N matching periods, the exact window bounds, holding the row and column after the flag drops, and the mapping of each tone to its index can only be shown by the bench scenarios. These drive square waves of chosen periods and follow a cycle-accurate behavioural model.

// File: rtl/dtmf_zc_pkg.sv
package dtmf_zc_pkg;

   localparam int NUM_TONES = 4;
   localparam int IDX_W     = 2;

   // grp 0 = low band, grp 1 = high band
   function automatic int tone_hz(input int grp, input int idx);
      int f;
      f = 0;
      if (grp == 0) begin
         case (idx)
            0: f = 697;
            1: f = 770;
            2: f = 852;
            default: f = 941;
         endcase
      end else begin
         case (idx)
            0: f = 1209;
            1: f = 1336;
            2: f = 1477;
            default: f = 1633;
         endcase
      end
      return f;
   endfunction

   // shortest accepted period (tone 2.5 % high), rounded up
   function automatic int period_lo(input int clk_hz, input int f);
      longint num;
      longint den;
      num = longint'(clk_hz) * 40;
      den = longint'(f) * 41;
      return int'((num + den - 1) / den);
   endfunction

   // longest accepted period (tone 2.5 % low), rounded down
   function automatic int period_hi(input int clk_hz, input int f);
      longint num;
      longint den;
      num = longint'(clk_hz) * 40;
      den = longint'(f) * 39;
      return int'(num / den);
   endfunction

endpackage

// File: rtl/zc_period_meter.sv
module zc_period_meter #(
   parameter int CNT_W   = 13,
   parameter int CNT_MAX = 5268
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_i,
   input  logic             sign_i,
   output logic             edge_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             prev_q;
   logic [CNT_W-1:0] cnt_q;

   assign edge_o = sign_i & ~prev_q;
   assign cnt_o  = cnt_q;
   assign ovf_o  = (cnt_q == SAT);

   always_ff @(posedge clk) begin
      if (!rst_n || pd_i) begin
         prev_q <= 1'b0;
         cnt_q  <= SAT;
      end else begin
         prev_q <= sign_i;
         if (edge_o)
            cnt_q <= ONE;
         else if (cnt_q != SAT)
            cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/zc_bin_classifier.sv
module zc_bin_classifier
   import dtmf_zc_pkg::*;
#(
   parameter int CLK_HZ = 3579545,
   parameter int GROUP  = 0,
   parameter int CNT_W  = 13
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] bin_o
);
   logic [NUM_TONES-1:0] match;

   for (genvar i = 0; i < NUM_TONES; i++) begin : g_win
      localparam int F  = tone_hz(GROUP, i);
      localparam int LO = period_lo(CLK_HZ, F);
      localparam int HI = period_hi(CLK_HZ, F);
      assign match[i] = (int'(cnt_i) >= LO) && (int'(cnt_i) <= HI);
   end

   always_comb begin
      hit_o = 1'b0;
      bin_o = '0;
      for (int i = 0; i < NUM_TONES; i++) begin
         if (match[i]) begin
            hit_o = 1'b1;
            bin_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/zc_band_lock.sv
module zc_band_lock
   import dtmf_zc_pkg::*;
#(
   parameter int LOCK_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_i,
   input  logic             edge_i,
   input  logic             ovf_i,
   input  logic             hit_i,
   input  logic [IDX_W-1:0] bin_i,
   output logic             locked_o,
   output logic [IDX_W-1:0] bin_o
);
   localparam int RUN_W = $clog2(LOCK_N + 1);
   localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_N);
   localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

   logic [RUN_W-1:0] run_q;
   logic [IDX_W-1:0] bin_q;

   assign locked_o = (run_q == RUN_FULL);
   assign bin_o    = bin_q;

   always_ff @(posedge clk) begin
      if (!rst_n || pd_i) begin
         run_q <= '0;
         bin_q <= '0;
      end else if (edge_i) begin
         if (hit_i) begin
            if (run_q != '0 && bin_i == bin_q) begin
               if (run_q != RUN_FULL)
                  run_q <= run_q + RUN_ONE;
            end else begin
               run_q <= RUN_ONE;
               bin_q <= bin_i;
            end
         end else begin
            run_q <= '0;
         end
      end else if (ovf_i) begin
         run_q <= '0;
      end
   end

   // lock may only appear on the clock that closed a period
   assert_lock_after_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(edge_i));

   // silence (saturated count) empties the run
   assert_ovf_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_i && !edge_i) |=> (run_q == '0));
endmodule

// File: rtl/dtmf_zc_pair_detect.sv
module dtmf_zc_pair_detect
   import dtmf_zc_pkg::*;
#(
   parameter int CLK_HZ = 3579545,
   parameter int LOCK_N = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       low_sign_i,
   input  logic       high_sign_i,
   input  logic       inhibit_i,
   input  logic       pwr_down_i,
   output logic       early_valid_o,
   output logic [1:0] row_o,
   output logic [1:0] col_o
);
   localparam int LOW_MAX = period_hi(CLK_HZ, tone_hz(0, 0)) + 1;
   localparam int CNT_W   = $clog2(LOW_MAX + 1);
   localparam logic [IDX_W-1:0] TOP_COL = IDX_W'(NUM_TONES - 1);

   if (LOCK_N < 2) begin : g_bad_lock
      $error("LOCK_N must be at least 2");
   end
   if (CLK_HZ < 20000) begin : g_bad_clk
      $error("CLK_HZ too low to separate neighbouring tone windows");
   end

   logic [1:0]       sign_v;
   logic [1:0]       lock_v;
   logic [IDX_W-1:0] bin_v [2];

   assign sign_v = {high_sign_i, low_sign_i};

   for (genvar g = 0; g < 2; g++) begin : g_band
      localparam int BAND_MAX = period_hi(CLK_HZ, tone_hz(g, 0)) + 1;

      logic             edge_w;
      logic             ovf_w;
      logic             hit_w;
      logic [CNT_W-1:0] cnt_w;
      logic [IDX_W-1:0] cls_w;

      zc_period_meter #(.CNT_W(CNT_W), .CNT_MAX(BAND_MAX)) u_meter (
         .clk(clk), .rst_n(rst_n), .pd_i(pwr_down_i), .sign_i(sign_v[g]),
         .edge_o(edge_w), .cnt_o(cnt_w), .ovf_o(ovf_w));

      zc_bin_classifier #(.CLK_HZ(CLK_HZ), .GROUP(g), .CNT_W(CNT_W)) u_cls (
         .cnt_i(cnt_w), .hit_o(hit_w), .bin_o(cls_w));

      zc_band_lock #(.LOCK_N(LOCK_N)) u_lock (
         .clk(clk), .rst_n(rst_n), .pd_i(pwr_down_i), .edge_i(edge_w),
         .ovf_i(ovf_w), .hit_i(hit_w), .bin_i(cls_w),
         .locked_o(lock_v[g]), .bin_o(bin_v[g]));
   end

   logic pair_ok;
   assign pair_ok = lock_v[0] && lock_v[1] && !(inhibit_i && bin_v[1] == TOP_COL);

   always_ff @(posedge clk) begin
      if (!rst_n || pwr_down_i) begin
         early_valid_o <= 1'b0;
         row_o         <= '0;
         col_o         <= '0;
      end else begin
         early_valid_o <= pair_ok;
         if (pair_ok) begin
            row_o <= bin_v[0];
            col_o <= bin_v[1];
         end
      end
   end

   assert_ev_needs_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      early_valid_o |-> $past(lock_v[0] && lock_v[1]));

   assert_drop_on_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock_v[0] && lock_v[1]) |=> !early_valid_o);

   assert_inhibit_col3_R9: assert property (@(posedge clk) disable iff (!rst_n)
      early_valid_o |-> !($past(inhibit_i) && col_o == TOP_COL));

   assert_pd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down_i |=> (!early_valid_o && row_o == 2'd0 && col_o == 2'd0));
endmodule

// File: tb/dtmf_zc_pair_detect_tb_top.sv
module dtmf_zc_pair_detect_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 100000;
   localparam int LOCK_N     = 4;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lo_s = 1'b0, hi_s = 1'b0, inh = 1'b0, pd = 1'b0;
   logic ev;
   logic [1:0] row, col;

   dtmf_zc_pair_detect #(.CLK_HZ(CLK_HZ), .LOCK_N(LOCK_N)) dut_i (
      .clk(clk), .rst_n(rst_n), .low_sign_i(lo_s), .high_sign_i(hi_s),
      .inhibit_i(inh), .pwr_down_i(pd),
      .early_valid_o(ev), .row_o(row), .col_o(col));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // tone windows from R5
   int tone[2][4] = '{'{697, 770, 852, 941}, '{1209, 1336, 1477, 1633}};
   int wlo[2][4], whi[2][4], cmax[2];
   initial begin
      for (int b = 0; b < 2; b++) begin
         for (int i = 0; i < 4; i++) begin
            wlo[b][i] = (CLK_HZ*40 + tone[b][i]*41 - 1) / (tone[b][i]*41);
            whi[b][i] = (CLK_HZ*40) / (tone[b][i]*39);
         end
         cmax[b] = whi[b][0] + 1;
      end
   end

   function automatic int bin_of(input int b, input int p);
      int r = -1;
      for (int i = 0; i < 4; i++)
         if (p >= wlo[b][i] && p <= whi[b][i]) r = i;
      return r;
   endfunction

   // square-wave generators, period in clocks (0 = silence)
   int per[2] = '{0, 0};
   int ph[2]  = '{0, 0};
   always @(negedge clk) begin
      for (int b = 0; b < 2; b++) begin
         bit v;
         if (per[b] == 0) begin
            ph[b] = 0;
            v = 1'b0;
         end else begin
            ph[b] = (ph[b] + 1 >= per[b]) ? 0 : ph[b] + 1;
            v = (ph[b] < per[b] / 2);
         end
         if (b == 0) lo_s = v; else hi_s = v;
      end
   end

   // behavioural reference
   int m_cnt[2], m_prev[2], m_run[2], m_bin[2];
   int m_ev = 0, m_row = 0, m_col = 0;
   int edges_lo = 0;
   always @(posedge clk) begin
      int s[2];
      s[0] = lo_s; s[1] = hi_s;
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) begin
            m_cnt[b] = cmax[b]; m_prev[b] = 0; m_run[b] = 0; m_bin[b] = 0;
         end
         m_ev = 0; m_row = 0; m_col = 0;
      end else begin
         bit pair;
         pair = (m_run[0] == LOCK_N) && (m_run[1] == LOCK_N) && !(inh && m_bin[1] == 3);
         if (pd) begin
            m_ev = 0; m_row = 0; m_col = 0;
         end else begin
            m_ev = pair;
            if (pair) begin m_row = m_bin[0]; m_col = m_bin[1]; end
         end
         if (s[0] && !m_prev[0]) edges_lo++;
         for (int b = 0; b < 2; b++) begin
            if (pd) begin
               m_cnt[b] = cmax[b]; m_prev[b] = 0; m_run[b] = 0; m_bin[b] = 0;
            end else begin
               int hb;
               hb = bin_of(b, m_cnt[b]);
               if (s[b] && !m_prev[b]) begin
                  if (hb >= 0) begin
                     if (m_run[b] > 0 && m_bin[b] == hb) begin
                        if (m_run[b] < LOCK_N) m_run[b]++;
                     end else begin
                        m_run[b] = 1; m_bin[b] = hb;
                     end
                  end else m_run[b] = 0;
                  m_cnt[b] = 1;
               end else if (m_cnt[b] == cmax[b]) m_run[b] = 0;
               else m_cnt[b]++;
               m_prev[b] = s[b];
            end
         end
      end
   end

   // per-cycle comparison and monitors
   bit saw_low = 0, rise_seen = 0;
   int rise_edges = 0;
   bit cmp_en = 0;
   always @(negedge clk) begin
      if (cmp_en && !done)
         chk({ev, row, col} == 5'(m_ev*16 + m_row*4 + m_col), cur_req,
             int'({ev, row, col}), m_ev*16 + m_row*4 + m_col);
      if (!ev) saw_low = 1;
      if (ev && !rise_seen) begin rise_seen = 1; rise_edges = edges_lo; end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      wait_cyc(1);
      chk(ev == 0 && row == 0 && col == 0, "R1", int'({ev, row, col}), 0);
      wait_cyc(2);
      cmp_en = 1;
      rst_n = 1'b1;
      wait_cyc(1);
      chk(ev == 0 && row == 0 && col == 0, "R1", int'({ev, row, col}), 0);

      // R2 / R3 / R4: several pairs
      cur_req = "R2";
      per[0] = 130; per[1] = 68;            // 770 Hz, 1477 Hz
      wait_cyc(1500);
      chk(ev == 1, "R4", ev, 1);
      chk(row == 1, "R2", row, 1);
      chk(col == 2, "R3", col, 2);
      per[0] = 117; per[1] = 75;            // 852 Hz, 1336 Hz
      wait_cyc(1500);
      chk(row == 2, "R2", row, 2);
      chk(col == 1, "R3", col, 1);
      per[0] = 106; per[1] = 83;            // 941 Hz, 1209 Hz
      wait_cyc(1500);
      chk(row == 3, "R2", row, 3);
      chk(col == 0, "R3", col, 0);

      // R5: window edges
      cur_req = "R5";
      per[0] = wlo[0][0]; per[1] = whi[1][3];
      wait_cyc(1500);
      chk(ev == 1 && row == 0 && col == 3, "R5", int'({ev, row, col}), 16 + 3);
      per[0] = wlo[0][0] - 1;
      wait_cyc(1500);
      chk(ev == 0, "R5", ev, 0);
      per[0] = whi[0][0] + 1;
      wait_cyc(1500);
      chk(ev == 0, "R5", ev, 0);
      per[0] = whi[0][0];
      wait_cyc(1500);
      chk(ev == 1 && row == 0, "R5", int'({ev, row}), 4);

      // R6: lock needs LOCK_N+1 crossings after silence
      cur_req = "R6";
      per[0] = 0;
      wait_cyc(400);
      chk(ev == 0, "R6", ev, 0);
      edges_lo = 0; rise_seen = 0;
      per[0] = 130;
      wait_cyc(1200);
      chk(rise_seen && rise_edges == LOCK_N + 1, "R6", rise_edges, LOCK_N + 1);

      // R7: one bad high-band period
      cur_req = "R7";
      saw_low = 0;
      per[1] = 71;
      wait_cyc(71);
      per[1] = 62;
      wait_cyc(600);
      chk(saw_low == 1, "R7", saw_low, 1);
      chk(ev == 1 && col == 3, "R7", int'({ev, col}), 7);

      // R8: silence on the low band
      cur_req = "R8";
      saw_low = 0;
      per[0] = 0;
      wait_cyc(10);
      chk(ev == 1 && saw_low == 0, "R8", ev, 1);
      wait_cyc(250);
      chk(ev == 0, "R8", ev, 0);
      chk(row == 1 && col == 3, "R11", int'({row, col}), 7);

      // R9: inhibit
      cur_req = "R9";
      inh = 1'b1; per[0] = 130; per[1] = 61;
      wait_cyc(800);
      chk(ev == 0, "R9", ev, 0);
      chk(row == 1 && col == 3, "R11", int'({row, col}), 7);
      per[1] = 83;
      wait_cyc(800);
      chk(ev == 1 && col == 0, "R9", int'({ev, col}), 4);
      inh = 1'b0; per[1] = 61;
      wait_cyc(800);
      chk(ev == 1 && col == 3, "R9", int'({ev, col}), 7);

      // R10: power-down
      cur_req = "R10";
      pd = 1'b1;
      wait_cyc(2);
      chk(ev == 0 && row == 0 && col == 0, "R10", int'({ev, row, col}), 0);
      wait_cyc(500);
      chk(ev == 0 && row == 0 && col == 0, "R10", int'({ev, row, col}), 0);
      pd = 1'b0;
      wait_cyc(1000);
      chk(ev == 1 && row == 1 && col == 3, "R10", int'({ev, row, col}), 16 + 7);

      finish_run();
   end
endmodule